// File: doc/BRIEF.md
# Extended-float versus signed-integer compare unit

This unit compares the value held in the top register of an eight-entry 80-bit extended-precision register stack against a signed integer operand of 16 or 32 bits. The integer is first widened exactly into extended format. The two values are then compared without regard to order, so the result also reports the case where they cannot be ordered. The result is a four-bit condition code with C3, C2, C1 and C0, plus three exception flags.

The caller supplies the stack top value, the current 3-bit top pointer, and the empty bits of all eight registers. A pop request retires the top register after the compare. The unit returns the updated pointer and the updated empty bits. A start strobe latches one compare, and the result appears with a done pulse one cycle later. The results then stay unchanged until the next start.

Top module: `fp_int_cmp`

## Requirements
- R1: When `wide_i`=1 the operand is the signed 32-bit `int_i`. When `wide_i`=0 the operand is the signed value of `int_i[15:0]`, and `int_i[31:16]` has no effect. Every value in the operand range is converted exactly.
- R2: `cc_o` is {C3,C2,C1,C0}. It is 4'b0000 when the stack top is greater than the operand, 4'b0001 when it is less, and 4'b1000 when the two are equal.
- R3: The stack top is unordered when it is a NaN or has an unsupported encoding. Unsupported encodings are: exponent 0x7FFF with bit 63 clear; or a nonzero exponent below 0x7FFF with bit 63 clear. An unordered top gives `cc_o`=4'b1101 and sets `inv_o`.
- R4: Negative zero and positive zero both compare equal to integer 0.
- R5: C1 (`cc_o[1]`) is 0 after every compare that finds a valid stack top.
- R6: A denormal stack top (exponent 0, mantissa nonzero) sets `den_o` and compares by its value.
- R7: If the top register's empty bit is set, the unit raises `und_o` and gives `cc_o`=4'b1101. In that case `inv_o` and `den_o` stay 0, and `top_o` and `tag_empty_o` equal the inputs.
- R8: A pop request on a valid top sets bit `top_i` of `tag_empty_o` and gives `top_o`=`top_i`+1 modulo 8. Without a pop, both outputs pass through the inputs.
- R9: `done_o` is high for exactly the one cycle after each `start_i` cycle. All results hold while `start_i` is low.
- R10: Positive infinity is greater than every integer, and negative infinity is less than every integer. Neither sets `inv_o`.
- R11: After reset, `cc_o`=0, every flag is 0, `top_o`=0 and `tag_empty_o`=8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one compare |
| st_val_i | input | 80 | Stack top value, extended format |
| top_i | input | 3 | Current top-of-stack pointer |
| tag_empty_i | input | 8 | Empty bit per stack register |
| int_i | input | 32 | Integer operand |
| wide_i | input | 1 | 1: 32-bit operand, 0: 16-bit operand |
| pop_i | input | 1 | Pop the stack after the compare |
| cc_o | output | 4 | Condition code {C3,C2,C1,C0} |
| inv_o | output | 1 | Invalid-operation flag |
| den_o | output | 1 | Denormal-operand flag |
| und_o | output | 1 | Stack-underflow flag |
| top_o | output | 3 | Updated top pointer |
| tag_empty_o | output | 8 | Updated empty bits |
| done_o | output | 1 | Result valid pulse |

## Verification
The only internal state is the result register. A wrong widening, a wrong class decision or a wrong magnitude compare therefore shows up in `cc_o` or the flags at the `done_o` cycle of the very compare that caused it. Nothing is left behind to surface later. The bench compares every pair drawn from a grid of real stack values and integers, at both operand widths, against comparisons done in real arithmetic. A fault in the pointer or the empty bits shows up in `top_o` or `tag_empty_o` on that same cycle, so the bench exercises the pop and underflow paths directly, including wrap from 7 to 0.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int BIAS  = 16383;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } ext_t;

  typedef enum logic [2:0] {
    CL_ZERO, CL_DEN, CL_NORM, CL_INF, CL_NAN, CL_BAD
  } cls_e;

  localparam logic [3:0] CC_GT = 4'b0000;
  localparam logic [3:0] CC_LT = 4'b0001;
  localparam logic [3:0] CC_EQ = 4'b1000;
  localparam logic [3:0] CC_UN = 4'b1101;
endpackage

// File: rtl/fic_widen.sv
module fic_widen
  import fic_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic [INT_W-1:0] int_i,
  input  logic             wide_i,
  output ext_t             ext_o
);
  localparam int LZ_W = $clog2(INT_W + 1);

  logic [INT_W-1:0] val, mag;
  logic [LZ_W-1:0]  lz;
  logic [MAN_W-1:0] man;

  always_comb begin
    val = wide_i ? int_i
                 : {{(INT_W-NARROW_W){int_i[NARROW_W-1]}}, int_i[NARROW_W-1:0]};
    mag = val[INT_W-1] ? (~val + 1'b1) : val;
    lz  = LZ_W'(INT_W);
    for (int i = 0; i < INT_W; i++)
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    man = {mag, {(MAN_W-INT_W){1'b0}}} << lz;
  end

  always_comb begin
    ext_o.sgn = val[INT_W-1];
    if (mag == '0) begin
      ext_o.exp = '0;
      ext_o.man = '0;
    end else begin
      ext_o.exp = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);
      ext_o.man = man;
    end
  end

  // R1: nonzero operand always lands normalised
  always_comb
    if (mag != '0) a_r1_normalised: assert (man[MAN_W-1]);
endmodule

// File: rtl/fic_classify.sv
module fic_classify
  import fic_pkg::*;
(
  input  ext_t x_i,
  output cls_e cls_o
);
  logic exp_max, exp_zero, jbit, frac_nz;

  always_comb begin
    exp_max  = &x_i.exp;
    exp_zero = ~|x_i.exp;
    jbit     = x_i.man[MAN_W-1];
    frac_nz  = |x_i.man[MAN_W-2:0];
    if (exp_zero)     cls_o = (x_i.man == '0) ? CL_ZERO : CL_DEN;
    else if (!jbit)   cls_o = CL_BAD;  // unnormal, pseudo-inf, pseudo-NaN
    else if (exp_max) cls_o = frac_nz ? CL_NAN : CL_INF;
    else              cls_o = CL_NORM;
  end

  // R3: a set integer bit never yields the unsupported class off exponent 0
  always_comb
    if (!exp_zero && jbit) a_r3_bad_needs_jclear: assert (cls_o != CL_BAD);
endmodule

// File: rtl/fic_order.sv
module fic_order
  import fic_pkg::*;
(
  input  ext_t a_i,
  input  ext_t b_i,
  output logic gt_o,
  output logic eq_o
);
  logic [EXP_W+MAN_W-1:0] ka, kb;
  logic sa, sb, mag_gt;

  always_comb begin
    ka     = {a_i.exp, a_i.man};
    kb     = {b_i.exp, b_i.man};
    sa     = a_i.sgn & (ka != '0);  // zero counts as positive
    sb     = b_i.sgn & (kb != '0);
    mag_gt = ka > kb;
    if (sa != sb) begin
      eq_o = 1'b0;
      gt_o = sb;
    end else begin
      eq_o = (ka == kb);
      gt_o = !eq_o && (sa ? !mag_gt : mag_gt);
    end
  end

  always_comb a_r2_not_both: assert (!(gt_o && eq_o));
endmodule

// File: rtl/fp_int_cmp.sv
module fp_int_cmp
  import fic_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int DEPTH    = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int VAL_W   = 1 + EXP_W + MAN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VAL_W-1:0] st_val_i,
  input  logic [PTR_W-1:0] top_i,
  input  logic [DEPTH-1:0] tag_empty_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             wide_i,
  input  logic             pop_i,
  output logic [3:0]       cc_o,
  output logic             inv_o,
  output logic             den_o,
  output logic             und_o,
  output logic [PTR_W-1:0] top_o,
  output logic [DEPTH-1:0] tag_empty_o,
  output logic             done_o
);
  ext_t st, src;
  cls_e st_cls;
  logic gt, eq, empty, unord;
  logic [3:0]       cc_d;
  logic [PTR_W-1:0] top_d;
  logic [DEPTH-1:0] tag_d;

  assign st = ext_t'(st_val_i);

  fic_widen #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_widen (
    .int_i(int_i), .wide_i(wide_i), .ext_o(src));
  fic_classify u_cls (.x_i(st), .cls_o(st_cls));
  fic_order    u_ord (.a_i(st), .b_i(src), .gt_o(gt), .eq_o(eq));

  always_comb begin
    empty = tag_empty_i[top_i];
    unord = (st_cls == CL_NAN) || (st_cls == CL_BAD);
    if (empty || unord) cc_d = CC_UN;
    else if (eq)        cc_d = CC_EQ;
    else if (gt)        cc_d = CC_GT;
    else                cc_d = CC_LT;
    top_d = top_i;
    tag_d = tag_empty_i;
    if (pop_i && !empty) begin
      top_d        = top_i + 1'b1;
      tag_d[top_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_o        <= '0;
      inv_o       <= 1'b0;
      den_o       <= 1'b0;
      und_o       <= 1'b0;
      top_o       <= '0;
      tag_empty_o <= '1;
      done_o      <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        cc_o        <= cc_d;
        inv_o       <= !empty && unord;
        den_o       <= !empty && (st_cls == CL_DEN);
        und_o       <= empty;
        top_o       <= top_d;
        tag_empty_o <= tag_d;
      end
    end
  end

  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cc_o == CC_GT || cc_o == CC_LT || cc_o == CC_EQ || cc_o == CC_UN));
  a_r3_inv_unordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && inv_o) |-> (cc_o == CC_UN));
  a_r7_und_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && tag_empty_i[top_i]) |=> (und_o && cc_o == CC_UN &&
      top_o == $past(top_i) && tag_empty_o == $past(tag_empty_i)));
  a_r8_pop_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && pop_i && !tag_empty_i[top_i]) |=>
      (top_o == $past(top_i) + 1'b1 && tag_empty_o[$past(top_i)]));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(cc_o) && $stable(top_o) && $stable(tag_empty_o)));
endmodule

// File: tb/fp_int_cmp_test.sv
module fp_int_cmp_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [79:0] st_val_i = '0;
  logic [2:0]  top_i = '0;
  logic [7:0]  tag_empty_i = '0;
  logic [31:0] int_i = '0;
  logic        wide_i = 1'b1;
  logic        pop_i = 1'b0;
  logic [3:0]  cc_o;
  logic        inv_o, den_o, und_o, done_o;
  logic [2:0]  top_o;
  logic [7:0]  tag_empty_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  fp_int_cmp uut (.*);

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] to_ext(input real r);
    logic [63:0] b;
    int e;
    b = $realtobits(r);
    if (r == 0.0) return {b[63], 79'b0};
    e = int'(b[62:52]) - 1023 + 16383;
    return {b[63], e[14:0], 1'b1, b[51:0], 11'b0};
  endfunction

  task automatic run(input logic [79:0] v, input logic [31:0] n, input logic w,
                     input logic p, input logic [2:0] t, input logic [7:0] tg);
    @(negedge clk_i);
    st_val_i = v; int_i = n; wide_i = w; pop_i = p; top_i = t; tag_empty_i = tg;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic expect_cc(input logic [3:0] cc, input string req);
    chk(done_o && cc_o == cc, req, {75'b0, done_o, cc_o}, {75'b0, 1'b1, cc});
  endtask

  initial begin
    #1200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    real reals[16];
    logic [31:0] ints[14];
    reals = '{0.0, -0.0, 1.0, -1.0, 0.5, 1.5, 32767.0, -32768.0, 2147483647.0,
              -2147483648.0, 2147483648.0, 65535.0, 1.0e10, -1.0e10, 3.25, -100.75};
    ints  = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd2, 32'hFFFF_FFFE, 32'd32767,
              32'hFFFF_8000, 32'd100, 32'hFFFF_FF9C, 32'd3, 32'h7FFF_FFFF,
              32'h8000_0000, 32'h0000_FFFF, 32'h1234_5678};
    #20;
    // R11 reset state
    chk(cc_o == 0 && !inv_o && !den_o && !und_o && !done_o && top_o == 0 && tag_empty_o == 8'hFF,
        "R11", {62'b0, cc_o, inv_o, den_o, und_o, done_o, top_o, tag_empty_o}, {69'b0, 3'b0, 8'hFF});
    rst_ni = 1'b1;

    // R1 R2 R4 R5 sweep at both widths
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 14; j++) begin
          real iv;
          logic [3:0] e;
          iv = (w == 1) ? real'($signed(ints[j])) : real'($signed(ints[j][15:0]));
          e = (reals[i] > iv) ? 4'b0000 : (reals[i] < iv) ? 4'b0001 : 4'b1000;
          run(to_ext(reals[i]), ints[j], w[0], 1'b0, 3'd2, 8'h00);
          expect_cc(e, (w == 1) ? "R1 R2 R4 R5 wide" : "R1 R2 R4 R5 narrow");
          chk(!inv_o && !den_o && !und_o, "R2 flags", {77'b0, inv_o, den_o, und_o}, 80'b0);
        end

    // R1 upper bits ignored in narrow mode
    run(to_ext(5.0), 32'hABCD_0005, 1'b0, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b1000, "R1 upper ignored");

    // R10 infinities
    run({1'b0, 15'h7FFF, 1'b1, 63'b0}, 32'h7FFF_FFFF, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b0000, "R10 +inf");
    chk(!inv_o, "R10 +inf inv", {79'b0, inv_o}, 80'b0);
    run({1'b1, 15'h7FFF, 1'b1, 63'b0}, 32'h8000_0000, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b0001, "R10 -inf");

    // R3 NaN and unsupported encodings
    run({1'b0, 15'h7FFF, 2'b11, 62'b0}, 32'd0, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b1101, "R3 qnan");
    chk(inv_o, "R3 qnan inv", {79'b0, inv_o}, 80'b1);
    run({1'b1, 15'h7FFF, 2'b10, 62'b1}, 32'd0, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b1101, "R3 snan");
    run({1'b0, 15'h7FFF, 64'b0}, 32'd1, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b1101, "R3 pseudo-inf");
    chk(inv_o, "R3 pseudo-inf inv", {79'b0, inv_o}, 80'b1);
    run({1'b0, 15'h4000, 1'b0, 63'h1}, 32'd1, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b1101, "R3 unnormal");
    chk(inv_o && !den_o, "R3 unnormal flags", {78'b0, inv_o, den_o}, {78'b0, 2'b10});

    // R6 denormals
    run({1'b0, 15'h0, 64'h1}, 32'd0, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b0000, "R6 +denorm vs 0");
    chk(den_o && !inv_o, "R6 den flag", {78'b0, den_o, inv_o}, {78'b0, 2'b10});
    run({1'b1, 15'h0, 64'h8}, 32'd0, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b0001, "R6 -denorm vs 0");
    run({1'b0, 15'h0, 64'h4}, 32'd1, 1'b1, 1'b0, 3'd0, 8'h00);
    expect_cc(4'b0001, "R6 denorm vs 1");
    run(to_ext(1.0), 32'd1, 1'b1, 1'b0, 3'd0, 8'h00);
    chk(!den_o, "R6 normal no den", {79'b0, den_o}, 80'b0);

    // R7 underflow, pop suppressed
    run(to_ext(2.0), 32'd2, 1'b1, 1'b1, 3'd5, 8'h20);
    expect_cc(4'b1101, "R7 underflow cc");
    chk(und_o && !inv_o && !den_o, "R7 flags", {77'b0, und_o, inv_o, den_o}, {77'b0, 3'b100});
    chk(top_o == 3'd5 && tag_empty_o == 8'h20, "R7 no pop",
        {69'b0, top_o, tag_empty_o}, {69'b0, 3'd5, 8'h20});

    // R8 pop, including wrap
    for (int t = 0; t < 8; t++) begin
      logic [2:0] nt;
      nt = 3'(t + 1);
      run(to_ext(7.0), 32'd7, 1'b1, 1'b1, 3'(t), 8'h00);
      chk(top_o == nt && tag_empty_o == (8'h01 << t) && !und_o, "R8 pop",
          {69'b0, top_o, tag_empty_o}, {69'b0, nt, 8'h01 << t});
      expect_cc(4'b1000, "R8 pop cc");
    end
    run(to_ext(7.0), 32'd7, 1'b1, 1'b0, 3'd6, 8'h81);
    chk(top_o == 3'd6 && tag_empty_o == 8'h81, "R8 no pop",
        {69'b0, top_o, tag_empty_o}, {69'b0, 3'd6, 8'h81});

    // R9 done falls, results hold
    @(negedge clk_i);
    st_val_i = to_ext(-9.0);
    int_i = 32'd100;
    top_i = 3'd1;
    @(negedge clk_i);
    chk(!done_o && cc_o == 4'b1000 && top_o == 3'd6 && tag_empty_o == 8'h81, "R9 hold",
        {68'b0, done_o, cc_o, top_o, tag_empty_o}, {68'b0, 1'b0, 4'b1000, 3'd6, 8'h81});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule